// File: doc/BRIEF.md
# Compare-and-Branch Resolution Unit

This block decides the outcome of conditional branches for a pipeline with 32-bit instructions. It handles three branch forms. The first compares two registers. The second compares one register against zero. The third tests a predicate flag that an earlier compare instruction set. The block also executes that compare instruction. The compare reports a flag-update strobe and the new flag value, and it never branches.

Each accepted operation is registered. Its result appears one cycle after the input, marked by an output valid. The target address is the branch's own PC plus a signed displacement scaled by two. How many displacement bits are used depends on the branch form and on the encoding mode: baseline or extended. Bits of the raw field above that width are ignored.

Every ordered comparison goes through a single signed greater-than comparator. Less-than and the zero test are formed by feeding it swapped operands.

Top module: `cbr_resolve_unit`

## Requirements
- R1: While `rst_ni` is low, and on the first output after reset, `valid_o`, `taken_o`, `flag_we_o`, `flag_o`, `illegal_o` and `target_o` are all zero.
- R2: An input accepted with `valid_i`=1 at a rising edge produces `valid_o`=1 in the following cycle. With `valid_i`=0, all outputs are zero in the following cycle.
- R3: Kind code 0 (register pair) is taken exactly when `rn_i` < `rm_i` as signed 64-bit values. Its target is `pc_i` + 2 × sext(`disp_i[7:0]`).
- R4: Kind code 1 (register versus zero) is taken exactly when `rn_i` is negative. Its target uses sext(`disp_i[12:0]`) when `ext_mode_i`=1 and sext(`disp_i[10:0]`) when `ext_mode_i`=0, scaled by 2. Higher bits of `disp_i` have no effect.
- R5: Kind code 2 (flag branch) is taken exactly when `flag_i`=1. Its target uses sext(`disp_i[22:0]`) when `ext_mode_i`=1 and sext(`disp_i[19:0]`) when `ext_mode_i`=0, scaled by 2.
- R6: Kind code 3 (compare greater) gives `flag_we_o`=1 and `flag_o` = (`rm_i` > `rn_i` signed). It gives `taken_o`=0 and `target_o`=0.
- R7: The branch kinds (codes 0, 1 and 2) always give `flag_we_o`=0 and `flag_o`=0.
- R8: Kind codes 4 to 7 give `illegal_o`=1 for that result, with `taken_o`=0, `flag_we_o`=0 and `target_o`=0. The legal codes give `illegal_o`=0.
- R9: The target address wraps modulo 2^64. For a branch kind, `target_o` carries the computed target whether or not the branch is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation present this cycle |
| kind_i | input | 3 | Operation kind: 0 pair, 1 zero, 2 flag, 3 compare, 4-7 illegal |
| ext_mode_i | input | 1 | 1 = extended displacement widths, 0 = baseline |
| rn_i | input | 64 | First register operand |
| rm_i | input | 64 | Second register operand |
| flag_i | input | 1 | Current predicate flag |
| pc_i | input | 64 | Address of the branch instruction |
| disp_i | input | 23 | Raw displacement field, low-aligned |
| valid_o | output | 1 | Result valid |
| taken_o | output | 1 | Branch taken |
| target_o | output | 64 | Branch target address |
| flag_we_o | output | 1 | Flag-update strobe (compare only) |
| flag_o | output | 1 | New flag value when `flag_we_o` is set |
| illegal_o | output | 1 | Unsupported kind code |

## Verification
The hardest case to reach from the ports is a displacement whose sign bit sits exactly at the field width in use, while the ignored high bits of the raw field hold the opposite pattern. A wrong width choice would then change both the sign and the size of the offset. The stimulus drives the same raw field for the zero-test and flag forms in both encoding modes, with the bits above the field filled with ones or zeros. It also pairs extreme displacements with a PC near the top of the address space to reach the wrap. Signed comparisons are exercised with operands of opposite sign and with equal operands, so that a swapped or unsigned comparator shows up.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  localparam int unsigned XLEN       = 64;
  localparam int unsigned DISP_IN_W  = 23;
  localparam int unsigned PAIR_W     = 8;
  localparam int unsigned ZERO_EXT_W = 13;
  localparam int unsigned ZERO_BAS_W = 11;
  localparam int unsigned FLAG_EXT_W = 23;
  localparam int unsigned FLAG_BAS_W = 20;

  typedef enum logic [2:0] {
    K_BR_PAIR = 3'd0,
    K_BR_ZERO = 3'd1,
    K_BR_FLAG = 3'd2,
    K_CMP_GT  = 3'd3
  } br_kind_e;
endpackage

// File: rtl/cbr_disp_sel.sv
module cbr_disp_sel
  import cbr_pkg::*;
#(
  parameter int unsigned W_OUT = XLEN
) (
  input  logic [DISP_IN_W-1:0] disp_i,
  input  logic [2:0]           kind_i,
  input  logic                 ext_mode_i,
  output logic [W_OUT-1:0]     byte_off_o
);
  localparam int unsigned NW = 5;
  localparam int unsigned WID [NW] = '{PAIR_W, ZERO_EXT_W, ZERO_BAS_W, FLAG_EXT_W, FLAG_BAS_W};

  logic [W_OUT-1:0] cand [NW];
  logic [W_OUT-1:0] sel_off;

  for (genvar g = 0; g < NW; g++) begin : g_sext
    assign cand[g] = {{(W_OUT-WID[g]){disp_i[WID[g]-1]}}, disp_i[WID[g]-1:0]};
  end

  always_comb begin
    unique case (kind_i)
      K_BR_PAIR: sel_off = cand[0];
      K_BR_ZERO: sel_off = ext_mode_i ? cand[1] : cand[2];
      K_BR_FLAG: sel_off = ext_mode_i ? cand[3] : cand[4];
      default:   sel_off = '0;
    endcase
  end

  // 16-bit instruction granule
  assign byte_off_o = {sel_off[W_OUT-2:0], 1'b0};
endmodule

// File: rtl/cbr_cmp.sv
module cbr_cmp #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         gt_o
);
  assign gt_o = $signed(a_i) > $signed(b_i);
endmodule

// File: rtl/cbr_resolve_unit.sv
module cbr_resolve_unit
  import cbr_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [2:0]           kind_i,
  input  logic                 ext_mode_i,
  input  logic [XLEN-1:0]      rn_i,
  input  logic [XLEN-1:0]      rm_i,
  input  logic                 flag_i,
  input  logic [XLEN-1:0]      pc_i,
  input  logic [DISP_IN_W-1:0] disp_i,
  output logic                 valid_o,
  output logic                 taken_o,
  output logic [XLEN-1:0]      target_o,
  output logic                 flag_we_o,
  output logic                 flag_o,
  output logic                 illegal_o
);
  logic [XLEN-1:0] cmp_a, cmp_b, byte_off;
  logic            gt;
  logic            is_br, legal;
  logic            taken_d, fwe_d, flag_d, ill_d;
  logic [XLEN-1:0] tgt_d;

  cbr_disp_sel #(.W_OUT(XLEN)) i_disp (
    .disp_i    (disp_i),
    .kind_i    (kind_i),
    .ext_mode_i(ext_mode_i),
    .byte_off_o(byte_off)
  );

  // Single comparator: rn<rm == rm>rn, rn<0 == 0>rn
  always_comb begin
    cmp_a = rm_i;
    cmp_b = rn_i;
    if (kind_i == K_BR_ZERO) cmp_a = '0;
  end

  cbr_cmp #(.W(XLEN)) i_cmp (
    .a_i (cmp_a),
    .b_i (cmp_b),
    .gt_o(gt)
  );

  always_comb begin
    is_br   = (kind_i == K_BR_PAIR) || (kind_i == K_BR_ZERO) || (kind_i == K_BR_FLAG);
    legal   = is_br || (kind_i == K_CMP_GT);
    ill_d   = valid_i && !legal;
    fwe_d   = valid_i && (kind_i == K_CMP_GT);
    flag_d  = fwe_d && gt;
    taken_d = 1'b0;
    if (valid_i) begin
      unique case (kind_i)
        K_BR_PAIR, K_BR_ZERO: taken_d = gt;
        K_BR_FLAG:            taken_d = flag_i;
        default:              taken_d = 1'b0;
      endcase
    end
    tgt_d = (valid_i && is_br) ? pc_i + byte_off : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      taken_o   <= 1'b0;
      target_o  <= '0;
      flag_we_o <= 1'b0;
      flag_o    <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      taken_o   <= taken_d;
      target_o  <= tgt_d;
      flag_we_o <= fwe_d;
      flag_o    <= flag_d;
      illegal_o <= ill_d;
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !taken_o && !flag_we_o && !illegal_o && target_o == '0));
  assert_cmp_no_branch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_o |-> (!taken_o && target_o == '0));
  assert_branch_keeps_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> (!flag_we_o && !flag_o));
  assert_flag_only_with_we_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |-> flag_we_o);
  assert_illegal_inert_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!taken_o && !flag_we_o && target_o == '0 && valid_o));
endmodule

// File: tb/test_cbr_resolve_unit.sv
module test_cbr_resolve_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  kind_i = '0;
  logic        ext_mode_i = 1'b0;
  logic [63:0] rn_i = '0, rm_i = '0, pc_i = '0;
  logic        flag_i = 1'b0;
  logic [22:0] disp_i = '0;
  logic        valid_o, taken_o, flag_we_o, flag_o, illegal_o;
  logic [63:0] target_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  cbr_resolve_unit i_cbr_resolve_unit (
    .clk_i, .rst_ni, .valid_i, .kind_i, .ext_mode_i, .rn_i, .rm_i, .flag_i,
    .pc_i, .disp_i, .valid_o, .taken_o, .target_o, .flag_we_o, .flag_o, .illegal_o
  );

  function automatic logic [63:0] sext(input logic [22:0] d, input int w);
    logic [63:0] v;
    v = 64'(d) << (64 - w);
    v = $signed(v) >>> (64 - w);
    return v;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive one op, sample the registered result one cycle later
  task automatic run_op(input logic [2:0] k, input logic ext, input logic [63:0] rn,
                        input logic [63:0] rm, input logic fl, input logic [63:0] pc,
                        input logic [22:0] d);
    @(negedge clk_i);
    valid_i = 1'b1; kind_i = k; ext_mode_i = ext; rn_i = rn; rm_i = rm;
    flag_i = fl; pc_i = pc; disp_i = d;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic expect_br(input string req, input logic tk, input logic [63:0] tgt);
    chk(req, "valid", 64'(valid_o), 64'd1);
    chk(req, "taken", 64'(taken_o), 64'(tk));
    chk(req, "target", target_o, tgt);
    chk(req, "flag_we", 64'(flag_we_o), 64'd0);
    chk(req, "illegal", 64'(illegal_o), 64'd0);
  endtask

  task automatic t_reset();
    chk("R1", "valid", 64'(valid_o), 0);
    chk("R1", "taken", 64'(taken_o), 0);
    chk("R1", "target", target_o, 0);
    chk("R1", "flag", 64'({flag_we_o, flag_o, illegal_o}), 0);
  endtask

  task automatic t_pair();
    logic [63:0] pc = 64'h1000;
    run_op(3'd0, 1'b0, 64'd5, 64'd9, 1'b0, pc, 23'h00007F);
    expect_br("R3", 1'b1, pc + 64'd254);
    run_op(3'd0, 1'b1, -64'sd3, 64'd2, 1'b0, pc, 23'h7FFF80);
    expect_br("R3", 1'b1, pc - 64'd256);
    run_op(3'd0, 1'b0, 64'd7, 64'd7, 1'b0, pc, 23'h000010);
    expect_br("R3", 1'b0, pc + 64'd32);
    run_op(3'd0, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 1'b0, pc, 23'h0);
    expect_br("R3", 1'b0, pc);
    chk("R7", "flag_o", 64'(flag_o), 0);
  endtask

  task automatic t_zero();
    logic [63:0] pc = 64'h0040_0000;
    logic [22:0] d = 23'h7FF000 | 23'h0FFF; // bit12=1, bit10=1, high bits set
    run_op(3'd1, 1'b1, -64'sd1, 64'd0, 1'b0, pc, d);
    expect_br("R4", 1'b1, pc + (sext(d, 13) << 1));
    run_op(3'd1, 1'b0, 64'd0, 64'd0, 1'b0, pc, d);
    expect_br("R4", 1'b0, pc + (sext(d, 11) << 1));
    // bit12=0 with bits above 12 set: extended positive, baseline uses bit10
    d = 23'h7FE000 | 23'h0400;
    run_op(3'd1, 1'b1, 64'd1, 64'd0, 1'b0, pc, d);
    expect_br("R4", 1'b0, pc + 64'h800);
    run_op(3'd1, 1'b0, 64'h8000_0000_0000_0000, 64'd0, 1'b0, pc, d);
    expect_br("R4", 1'b1, pc - 64'h800);
  endtask

  task automatic t_flag();
    logic [63:0] pc = 64'h0100_0000;
    run_op(3'd2, 1'b1, 64'd0, 64'd0, 1'b1, pc, 23'h400000);
    expect_br("R5", 1'b1, pc - 64'h80_0000);
    run_op(3'd2, 1'b0, 64'd0, 64'd0, 1'b0, pc, 23'h400000);
    expect_br("R5", 1'b0, pc);
    run_op(3'd2, 1'b0, 64'd0, 64'd0, 1'b1, pc, 23'h0FFFFF);
    expect_br("R5", 1'b1, pc - 64'd2);
    run_op(3'd2, 1'b1, 64'd0, 64'd0, 1'b1, pc, 23'h0FFFFF);
    expect_br("R5", 1'b1, pc + 64'h1F_FFFE);
    chk("R7", "flag_o", 64'(flag_o), 0);
  endtask

  task automatic t_cmp();
    run_op(3'd3, 1'b0, 64'd3, 64'd8, 1'b0, 64'h2000, 23'h7F);
    chk("R6", "flag_we", 64'(flag_we_o), 1);
    chk("R6", "flag", 64'(flag_o), 1);
    chk("R6", "taken", 64'(taken_o), 0);
    chk("R6", "target", target_o, 0);
    run_op(3'd3, 1'b1, 64'd8, 64'd8, 1'b1, 64'h2000, 23'h7F);
    chk("R6", "flag eq", 64'(flag_o), 0);
    run_op(3'd3, 1'b1, 64'd1, -64'sd1, 1'b0, 64'h2000, 23'h0);
    chk("R6", "flag signed", 64'(flag_o), 0);
    chk("R6", "flag_we", 64'(flag_we_o), 1);
  endtask

  task automatic t_illegal();
    for (int k = 4; k < 8; k++) begin
      run_op(3'(k), 1'b1, 64'd1, 64'd2, 1'b1, 64'h3000, 23'h10);
      chk("R8", "illegal", 64'(illegal_o), 1);
      chk("R8", "taken", 64'(taken_o), 0);
      chk("R8", "flag_we", 64'(flag_we_o), 0);
      chk("R8", "target", target_o, 0);
    end
  endtask

  task automatic t_idle();
    run_op(3'd2, 1'b1, 64'd0, 64'd0, 1'b1, 64'h5000, 23'h5);
    @(negedge clk_i);
    chk("R2", "valid idle", 64'(valid_o), 0);
    chk("R2", "taken idle", 64'(taken_o), 0);
    chk("R2", "target idle", target_o, 0);
  endtask

  task automatic t_wrap();
    logic [63:0] pc = 64'hFFFF_FFFF_FFFF_FFF0;
    run_op(3'd0, 1'b0, 64'd0, 64'd1, 1'b0, pc, 23'h7F);
    expect_br("R9", 1'b1, 64'h0000_0000_0000_00EE);
    run_op(3'd2, 1'b1, 64'd0, 64'd0, 1'b0, 64'h10, 23'h7FFFF0);
    expect_br("R9", 1'b0, 64'hFFFF_FFFF_FFFF_FFF0);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_pair();
    t_zero();
    t_flag();
    t_cmp();
    t_illegal();
    t_idle();
    t_wrap();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule